// File: doc/BRIEF.md
# Shared-Cause Split Interrupt Controller

This block collects up to 32 hardware event pulses into one sticky cause register. A single unmask register qualifies every cause bit. The qualified bits are split into two level-sensitive interrupt lines. A fixed group of four bits (24 to 27 by default) carries the legacy INTx events and drives one line. Every other bit drives the error line. Software inspects and acknowledges events through a small register port. A read has no side effect. A write to the cause register clears only the bit positions written as 1. A write to the unmask register replaces its whole value.

Two separate handlers can each acknowledge only their own events, because clearing one bit never disturbs another pending event. Both lines stay asserted while any qualifying unmasked bit remains set. A line comes back after a partial clear if a qualifying bit is still pending.

Top module: `irq_split_ctrl`

## Requirements
- R1: After reset the cause register reads 0, the unmask register reads 0, and both interrupt outputs are low.
- R2: A 1 on evt_i bit b at a rising clock edge sets cause bit b at that edge, and the bit then stays set until software clears it.
- R3: The read port is combinational. reg_sel_i = 0 selects the cause register and reg_sel_i = 1 selects the unmask register. A cycle with reg_wr_i = 0 changes neither register.
- R4: A write with reg_sel_i = 0 clears each cause bit whose reg_wdata_i bit is 1 and leaves each bit whose reg_wdata_i bit is 0 unchanged.
- R5: A write with reg_sel_i = 1 loads all 32 bits of reg_wdata_i into the unmask register. An unmask bit of 1 enables that event.
- R6: When an event and a clear hit the same cause bit in the same cycle, the bit ends up set.
- R7: irq_intx_o is registered. After each clock edge it equals the OR of cause[27:24] AND unmask[27:24], using the register values updated at that edge.
- R8: irq_err_o is registered. After each clock edge it equals the OR of cause AND unmask over every bit except 24 to 27.
- R9: A pending but masked cause bit stays set and readable. Its output rises at the same edge where a write sets its unmask bit.
- R10: Clearing one pending event leaves every other pending event set. An output stays high while another qualifying unmasked bit is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Event pulses, one per cause bit |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_sel_i | input | 1 | Register select: 0 cause, 1 unmask |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| irq_intx_o | output | 1 | Level output for the legacy INTx group |
| irq_err_o | output | 1 | Level output for all other events |

## Verification
The hardest situation to reach from the ports is an event and an acknowledge landing on the same bit in the same cycle while other events stay pending. The stimulus first walks every bit position on its own through four steps: set, masked hold, unmask, then a zero-write and a one-write clear. It then drives a set together with a clear on that same bit. A scripted partial-clear sequence across both groups follows. A pseudo-random phase mixes simultaneous events, clears and unmask writes, and a reference model in the bench tracks the expected state.

// File: rtl/irq_split_pkg.sv
package irq_split_pkg;
  localparam int unsigned IRQ_W_DEF   = 32;
  localparam int unsigned INTX_LO_DEF = 24;
  localparam int unsigned INTX_N_DEF  = 4;

  typedef enum logic {
    SEL_CAUSE  = 1'b0,
    SEL_UNMASK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] cause_d_o,
  output logic [W-1:0] cause_q_o
);
  logic [W-1:0] cause_d;
  logic [W-1:0] cause_q;

  // A set applied in the same cycle as a clear wins.
  always_comb begin
    cause_d = (cause_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= cause_d;
  end

  assign cause_d_o = cause_d;
  assign cause_q_o = cause_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_d_o,
  output logic [W-1:0] mask_q_o
);
  logic [W-1:0] mask_d;
  logic [W-1:0] mask_q;

  always_comb begin
    mask_d = mask_q;
    if (wr_en_i) mask_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  assign mask_d_o = mask_d;
  assign mask_q_o = mask_q;
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
  parameter int unsigned W       = 32,
  parameter int unsigned INTX_LO = 24,
  parameter int unsigned INTX_N  = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cause_d_i,
  input  logic [W-1:0] mask_d_i,
  output logic         intx_o,
  output logic         err_o
);
  logic [W-1:0] grp_sel;
  logic [W-1:0] qual;
  logic         intx_d, err_d, intx_q, err_q;

  // Mark the bit positions that belong to the legacy group.
  for (genvar g = 0; g < W; g++) begin : g_grp
    if (g >= INTX_LO && g < INTX_LO + INTX_N) begin : g_in
      assign grp_sel[g] = 1'b1;
    end else begin : g_out
      assign grp_sel[g] = 1'b0;
    end
  end

  always_comb begin
    qual   = cause_d_i & mask_d_i;
    intx_d = |(qual & grp_sel);
    err_d  = |(qual & ~grp_sel);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      intx_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      intx_q <= intx_d;
      err_q  <= err_d;
    end
  end

  assign intx_o = intx_q;
  assign err_o  = err_q;
endmodule

// File: rtl/irq_split_ctrl.sv
module irq_split_ctrl
  import irq_split_pkg::*;
#(
  parameter int unsigned W       = IRQ_W_DEF,
  parameter int unsigned INTX_LO = INTX_LO_DEF,
  parameter int unsigned INTX_N  = INTX_N_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         reg_wr_i,
  input  logic         reg_sel_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  output logic         irq_intx_o,
  output logic         irq_err_o
);
  reg_sel_e     sel;
  logic [W-1:0] clr_vec;
  logic         mask_wr;
  logic [W-1:0] cause_d, cause_q, unmask_d, unmask_q;

  always_comb begin
    sel     = reg_sel_e'(reg_sel_i);
    clr_vec = (reg_wr_i && sel == SEL_CAUSE) ? reg_wdata_i : '0;
    mask_wr = reg_wr_i && sel == SEL_UNMASK;
  end

  irq_cause_reg #(.W(W)) u_cause (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(evt_i), .clr_i(clr_vec),
    .cause_d_o(cause_d), .cause_q_o(cause_q)
  );

  irq_mask_reg #(.W(W)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(mask_wr), .wdata_i(reg_wdata_i),
    .mask_d_o(unmask_d), .mask_q_o(unmask_q)
  );

  irq_out_gen #(.W(W), .INTX_LO(INTX_LO), .INTX_N(INTX_N)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .cause_d_i(cause_d), .mask_d_i(unmask_d),
    .intx_o(irq_intx_o), .err_o(irq_err_o)
  );

  always_comb begin
    reg_rdata_o = (sel == SEL_UNMASK) ? unmask_q : cause_q;
  end
endmodule

// File: rtl/irq_split_chk.sv
module irq_split_chk #(
  parameter int unsigned W       = 32,
  parameter int unsigned INTX_LO = 24,
  parameter int unsigned INTX_N  = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] evt_i,
  input logic         reg_wr_i,
  input logic         reg_sel_i,
  input logic [W-1:0] reg_wdata_i,
  input logic [W-1:0] cause_q,
  input logic [W-1:0] unmask_q,
  input logic         irq_intx_o,
  input logic         irq_err_o
);
  function automatic logic [W-1:0] grp_bits();
    logic [W-1:0] m = '0;
    for (int i = 0; i < W; i++)
      if (i >= INTX_LO && i < INTX_LO + INTX_N) m[i] = 1'b1;
    return m;
  endfunction
  localparam logic [W-1:0] GRP = grp_bits();

  logic [W-1:0] clr_now;
  assign clr_now = (reg_wr_i && !reg_sel_i) ? reg_wdata_i : '0;

  a_r2_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

  a_r3_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_wr_i && evt_i == '0) |=> ($stable(cause_q) && $stable(unmask_q)));

  a_r4_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !reg_sel_i) |=> ((cause_q & $past(reg_wdata_i) & ~$past(evt_i)) == '0));

  a_r10_others_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cause_q & $past(cause_q & ~clr_now)) == $past(cause_q & ~clr_now)));

  a_r5_unmask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_sel_i) |=> (unmask_q == $past(reg_wdata_i)));

  a_r7_intx_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_intx_o == (|(cause_q & unmask_q & GRP)));

  a_r8_err_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_err_o == (|(cause_q & unmask_q & ~GRP)));
endmodule

bind irq_split_ctrl irq_split_chk #(.W(W), .INTX_LO(INTX_LO), .INTX_N(INTX_N)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .reg_wr_i(reg_wr_i),
  .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i), .cause_q(cause_q),
  .unmask_q(unmask_q), .irq_intx_o(irq_intx_o), .irq_err_o(irq_err_o)
);

// File: tb/irq_split_ctrl_tb_top.sv
module irq_split_ctrl_tb_top;
  localparam logic [31:0] GRP = 32'h0F00_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt = '0;
  logic        wr = 1'b0;
  logic        sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        intx, err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] m_cause = '0;
  logic [31:0] m_mask = '0;

  always #10 clk = ~clk;

  irq_split_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .reg_wr_i(wr), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_intx_o(intx), .irq_err_o(err)
  );

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Reads both registers and both outputs against the model.
  task automatic chk_all(string rq);
    sel = 1'b0; #1;
    chk({rq, " cause"}, rdata, m_cause);
    sel = 1'b1; #1;
    chk({rq, " unmask"}, rdata, m_mask);
    chk({rq, " intx"}, {31'b0, intx}, {31'b0, |(m_cause & m_mask & GRP)});
    chk({rq, " err"}, {31'b0, err}, {31'b0, |(m_cause & m_mask & ~GRP)});
  endtask

  task automatic step(logic [31:0] e, logic w, logic s, logic [31:0] d);
    @(negedge clk);
    evt = e; wr = w; sel = s; wdata = d;
    if (w && !s) m_cause = m_cause & ~d;
    if (w && s)  m_mask = d;
    m_cause = m_cause | e;
    @(posedge clk); #2;
    evt = '0; wr = 1'b0; wdata = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1;
    chk_all("R1 reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk_all("R1 after release");

    for (int b = 0; b < 32; b++) begin
      step(32'h1 << b, 1'b0, 1'b0, '0);
      chk_all("R2 set, R9 masked hold");
      step('0, 1'b0, 1'b0, '0);
      chk_all("R2 sticky");
      step('0, 1'b1, 1'b1, 32'h1 << b);
      chk_all(b >= 24 && b <= 27 ? "R9 R7 intx unmask" : "R9 R8 err unmask");
      step('0, 1'b1, 1'b0, ~(32'h1 << b));
      chk_all("R4 zero write keeps");
      step('0, 1'b1, 1'b0, 32'h1 << b);
      chk_all("R4 one write clears");
      step(32'h1 << b, 1'b1, 1'b0, 32'h1 << b);
      chk_all("R6 set wins");
      step('0, 1'b1, 1'b0, 32'h1 << b);
      step('0, 1'b1, 1'b1, '0);
      chk_all("R5 unmask cleared");
    end

    step(32'h0F03_0000, 1'b1, 1'b1, 32'hFFFF_FFFF);
    chk_all("R10 all pending");
    step('0, 1'b1, 1'b0, 32'h0001_0000);
    chk_all("R10 clear 16 keeps 17");
    step('0, 1'b1, 1'b0, 32'h0100_0000);
    chk_all("R10 clear 24 keeps intx");
    step('0, 1'b1, 1'b0, 32'h0002_0000);
    chk_all("R10 err drops");
    step('0, 1'b1, 1'b0, 32'h0E00_0000);
    chk_all("R10 intx drops");

    step(32'hA5A5_5A5A, 1'b1, 1'b1, 32'h3C3C_C3C3);
    for (int k = 0; k < 6; k++) begin
      step('0, 1'b0, k[0], 32'hFFFF_FFFF);
      chk_all("R3 read no side effect");
    end

    r = 32'h1234_5679;
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r2;
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      r2 = {r[15:0], r[31:16]} ^ 32'h9E37_79B9;
      step(r & (r >> 3) & (r >> 7), r[0], r[1], r2);
      chk_all("R4 R5 R6 R7 R8 mixed");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule